// File: doc/BRIEF.md
# Synchronous PCI Clock Stop Controller

This block takes one free-running PCI-rate clock and hands out two groups of gated copies. The stoppable group can be halted and restarted in step with the source clock. The other group can be set, output by output, to keep running regardless. Two sources can ask for a stop: an active-low pin that arrives asynchronously, and a run bit held in a small control register. Either one is enough. A stopped output is parked at logic low. Restarting brings back whole pulses aligned to the source clock.

The pin goes through a two-flop synchroniser clocked by the PCI clock. Its synchronised level is then ANDed with the register run bit to give the effective run condition. Each output has an enable latch that is transparent only while the clock is low, so the output is `clk & latch`. Starting or stopping an output can therefore never cut a high pulse short. The register readback does not show the stored run bit. It shows the effective run condition, so software sees 0 whenever the stoppable clocks are halted, whichever source caused it. There is no data stream, so every port is a plain level signal. The register write port is a single-cycle write strobe with no back-pressure.

Top module: `pci_clkstop_ctrl`

## Requirements
- R1: `stop_pin_n` is active low and is sampled on rising edges of `clk_pci`. If it changes after rising edge k and before rising edge k+1 (meeting set-up to k+1, with k+1 counted as edge k below), the stoppable outputs still give full high pulses at edges k and k+1. They take the new state from edge k+2.
- R2: The stoppable outputs run only when the synchronised pin is high and the register run bit (bit 0 of `cfg_wdata`, 1 = run) is also high. If either one is low, they stop.
- R3: While stopped, every stoppable output is held at logic low for the whole clock period and never goes high.
- R4: Bit 0 of `cfg_rdata` is the effective run condition, the AND of the synchronised pin and the stored run bit. It reads 0 whenever either one is low. Bits N_FREE:1 of `cfg_rdata` read back the stored free-run bits.
- R5: Bit i+1 of the register is the free-run bit for `pcif_clk_out[i]`. When it is 1, that output keeps running whatever the stop request. When it is 0, that output stops and starts together with `pci_clk_out`.
- R6: Once the stop request is removed, the stopped outputs resume within two PCI clock periods. Their first pulse after the restart is a full-width high pulse aligned to `clk_pci`.
- R7: Every high pulse on every output lasts exactly one full high phase of `clk_pci`. Starting or stopping never produces a shortened pulse.
- R8: After reset the run bit is 1, the free-run bits are 0 and the synchroniser holds "run", so with the pin high all outputs run and `cfg_rdata` reads 1.
- R9: When `cfg_we` is high at a rising edge k, `cfg_wdata` is stored at edge k. A change of the run bit or of a free-run bit affects the outputs from edge k+1 onwards.

Note on R9: the R1 and R9 latencies differ because the register path does not pass through the synchroniser. A pin change takes effect two edges after it is sampled; a register write takes effect one edge after it is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci | input | 1 | Ungated PCI-rate source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_pin_n | input | 1 | Asynchronous active-low stop request pin |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | N_FREE+1 | Write data: bit 0 is the run bit, bits N_FREE:1 are the free-run bits |
| cfg_rdata | output | N_FREE+1 | Readback: bit 0 is the effective run state, upper bits are the free-run bits |
| pci_clk_out | output | N_STOP | Stoppable gated PCI clocks |
| pcif_clk_out | output | N_FREE | PCI clocks that can each be set to free-run |

## Verification
The bench measures the width of every high pulse on the outputs. A gate that does not use a latch, or that changes its enable while the clock is high, produces a short pulse and fails. It samples the outputs at the exact edges where a pin change or a register write should take effect. This catches a synchroniser with missing or extra stages, and a gate that passes the enable straight through with no register. It drives all four combinations of pin and run bit and compares the readback with their AND. A readback that returns the stored bit would show "running" while the pin alone has stopped the clocks. Finally, it sets a free-run bit and clears it again while a stop is in force. This shows whether the bit really overrides the stop and whether clearing it parks the output low.

// File: rtl/pci_clkstop_pkg.sv
package pci_clkstop_pkg;
  // Register field positions shared by the write port and the readback.
  localparam int unsigned RUN_BIT  = 0;
  localparam int unsigned FREE_LSB = 1;

  // Reset level of the synchroniser and of the run bit: running.
  localparam logic RUN_RESET = 1'b1;

  function automatic int unsigned cfg_width(input int unsigned n_free);
    return n_free + 1;
  endfunction
endpackage

// File: rtl/pcs_sync.sv
module pcs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_async};
  end

  assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pcs_cfg_reg.sv
module pcs_cfg_reg
  import pci_clkstop_pkg::*;
#(
  parameter int unsigned N_FREE = 2,
  localparam int unsigned CW    = N_FREE + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [CW-1:0]     wdata,
  input  logic              pin_run,
  output logic              run_q,
  output logic [N_FREE-1:0] free_q,
  output logic [CW-1:0]     rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= RUN_RESET;
      free_q <= '0;
    end else if (we) begin
      run_q  <= wdata[RUN_BIT];
      free_q <= wdata[FREE_LSB +: N_FREE];
    end
  end

  // Readback reports the combined run state rather than the stored bit.
  always_comb begin
    rdata                      = '0;
    rdata[RUN_BIT]             = run_q & pin_run;
    rdata[FREE_LSB +: N_FREE]  = free_q;
  end
endmodule

// File: rtl/pcs_clk_gate.sv
module pcs_clk_gate #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic [N-1:0] en_d,
  output logic [N-1:0] en_lat,
  output logic [N-1:0] gclk
);
  for (genvar g = 0; g < N; g++) begin : g_gate
    logic lat_q;

    // Transparent only while the clock is low: the enable can only
    // change between pulses, never inside one.
    always_latch begin
      if (!clk) lat_q <= en_d[g];
    end

    assign en_lat[g] = lat_q;
    assign gclk[g]   = clk & lat_q;
  end
endmodule

// File: rtl/pci_clkstop_ctrl.sv
module pci_clkstop_ctrl
  import pci_clkstop_pkg::*;
#(
  parameter int unsigned N_STOP      = 4,
  parameter int unsigned N_FREE      = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_pci,
  input  logic              rst_n,
  input  logic              stop_pin_n,
  input  logic              cfg_we,
  input  logic [N_FREE:0]   cfg_wdata,
  output logic [N_FREE:0]   cfg_rdata,
  output logic [N_STOP-1:0] pci_clk_out,
  output logic [N_FREE-1:0] pcif_clk_out
);
  localparam int unsigned CW = cfg_width(N_FREE);

  logic              pin_run_s;
  logic              run_q;
  logic [N_FREE-1:0] free_q;
  logic              run_eff;
  logic [N_STOP-1:0] stop_en_d, stop_en_lat;
  logic [N_FREE-1:0] free_en_d, free_en_lat;

  pcs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(RUN_RESET)) u_sync (
    .clk     (clk_pci),
    .rst_n   (rst_n),
    .d_async (stop_pin_n),
    .q_sync  (pin_run_s)
  );

  pcs_cfg_reg #(.N_FREE(N_FREE)) u_cfg (
    .clk     (clk_pci),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata[CW-1:0]),
    .pin_run (pin_run_s),
    .run_q   (run_q),
    .free_q  (free_q),
    .rdata   (cfg_rdata)
  );

  assign run_eff   = cfg_rdata[RUN_BIT];
  assign stop_en_d = {N_STOP{run_eff}};
  assign free_en_d = free_q | {N_FREE{run_eff}};

  pcs_clk_gate #(.N(N_STOP)) u_gate_stop (
    .clk    (clk_pci),
    .en_d   (stop_en_d),
    .en_lat (stop_en_lat),
    .gclk   (pci_clk_out)
  );

  pcs_clk_gate #(.N(N_FREE)) u_gate_free (
    .clk    (clk_pci),
    .en_d   (free_en_d),
    .en_lat (free_en_lat),
    .gclk   (pcif_clk_out)
  );

  // Cycles since reset release, saturating; used by the checks below only.
  logic [1:0] rst_age;
  always_ff @(posedge clk_pci or negedge rst_n) begin
    if (!rst_n)               rst_age <= '0;
    else if (rst_age != 2'd2) rst_age <= rst_age + 2'd1;
  end

  AST_PIN_SYNC_LAT: assert property (@(posedge clk_pci) disable iff (!rst_n)
    (rst_age == 2'd2) |-> (pin_run_s == $past(stop_pin_n, 2)));          // R1

  AST_STOPPED_LOW: assert property (@(posedge clk_pci) disable iff (!rst_n)
    ((rst_age != 2'd0) && !run_eff) |-> (stop_en_lat == '0));            // R3

  AST_REG_STOP_READBACK: assert property (@(posedge clk_pci) disable iff (!rst_n)
    ((rst_age != 2'd0) && $past(cfg_we && !cfg_wdata[RUN_BIT]))
      |-> !cfg_rdata[RUN_BIT]);                                          // R4

  AST_FREE_IGNORES_STOP: assert property (@(posedge clk_pci) disable iff (!rst_n)
    (rst_age != 2'd0) |-> ((free_q & ~free_en_lat) == '0));              // R5

  AST_RESUME_FULL: assert property (@(posedge clk_pci) disable iff (!rst_n)
    ((rst_age == 2'd2) && $rose(run_eff)) |-> (&stop_en_lat));           // R6
endmodule

// File: tb/pci_clkstop_ctrl_tb.sv
`timescale 1ns/1ps
module pci_clkstop_ctrl_tb;
  localparam int unsigned NS = 4;
  localparam int unsigned NF = 2;
  localparam real HALF = 4.0;

  logic          clk_pci = 1'b0;
  logic          rst_n = 1'b0;
  logic          stop_pin_n = 1'b1;
  logic          cfg_we = 1'b0;
  logic [NF:0]   cfg_wdata = '0;
  logic [NF:0]   cfg_rdata;
  logic [NS-1:0] pci_clk_out;
  logic [NF-1:0] pcif_clk_out;

  int n_checks = 0;
  int n_fail   = 0;
  int runts    = 0;
  int pulses   = 0;

  always #(HALF) clk_pci = ~clk_pci;

  pci_clkstop_ctrl #(.N_STOP(NS), .N_FREE(NF)) u_dut (
    .clk_pci(clk_pci), .rst_n(rst_n), .stop_pin_n(stop_pin_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .pci_clk_out(pci_clk_out), .pcif_clk_out(pcif_clk_out)
  );

  // Pulse-width monitors (R7).
  for (genvar i = 0; i < NS + NF; i++) begin : g_mon
    logic o;
    realtime t_rise;
    if (i < NS) begin : g_s
      assign o = pci_clk_out[i];
    end else begin : g_f
      assign o = pcif_clk_out[i-NS];
    end
    always @(posedge o) t_rise = $realtime;
    always @(negedge o) begin
      if (rst_n) begin
        pulses++;
        if (($realtime - t_rise) < HALF - 0.01 || ($realtime - t_rise) > HALF + 0.01)
          runts++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Move to the sample point (2 ns into the high phase) of the n-th next edge.
  task automatic edges(input int n);
    repeat (n) @(posedge clk_pci);
    #2;
  endtask

  // Change the pin before the next edge; return at that edge's sample point.
  task automatic set_pin(input logic v);
    @(negedge clk_pci);
    stop_pin_n = v;
    edges(1);
  endtask

  // Write the register at the next edge; return at that edge's sample point.
  task automatic wr(input logic [NF:0] d);
    @(negedge clk_pci);
    cfg_we = 1'b1;
    cfg_wdata = d;
    edges(1);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset;
    edges(1);
    chk(cfg_rdata == 3'b001, "R8 readback", cfg_rdata, 1);
    chk(pci_clk_out == '1, "R8 stoppable running", pci_clk_out, 15);
    chk(pcif_clk_out == '1, "R8 free group running", pcif_clk_out, 3);
  endtask

  task automatic t_pin_stop;
    set_pin(1'b0);
    chk(pci_clk_out == '1, "R1 edge k still running", pci_clk_out, 15);
    edges(1);
    chk(pci_clk_out == '1, "R1 edge k+1 still running", pci_clk_out, 15);
    edges(1);
    chk(pci_clk_out == '0, "R1 stopped at edge k+2", pci_clk_out, 0);
    chk(pcif_clk_out == '0, "R5 cleared bit stops with group", pcif_clk_out, 0);
    chk(cfg_rdata[0] == 1'b0, "R4 pin stop readback", cfg_rdata[0], 0);
    for (int c = 0; c < 3; c++) begin
      #4;  // low phase
      chk(pci_clk_out == '0, "R3 low in low phase", pci_clk_out, 0);
      edges(1);
      chk(pci_clk_out == '0, "R3 low in high phase", pci_clk_out, 0);
    end
    set_pin(1'b1);
    chk(pci_clk_out == '0, "R6 edge k still stopped", pci_clk_out, 0);
    edges(1);
    edges(1);
    chk(pci_clk_out == '1, "R6 resumed by edge k+2", pci_clk_out, 15);
    chk(pcif_clk_out == '1, "R6 stoppable free outputs resumed", pcif_clk_out, 3);
  endtask

  task automatic t_reg_stop;
    wr(3'b000);
    chk(pci_clk_out == '1, "R9 write edge still running", pci_clk_out, 15);
    edges(1);
    chk(pci_clk_out == '0, "R9 R2 register stop at k+1", pci_clk_out, 0);
    chk(cfg_rdata == 3'b000, "R4 register stop readback", cfg_rdata, 0);
    wr(3'b001);
    edges(1);
    chk(pci_clk_out == '1, "R9 R6 register restart at k+1", pci_clk_out, 15);
  endtask

  task automatic t_combos;
    for (int p = 0; p < 2; p++) begin
      for (int b = 0; b < 2; b++) begin
        @(negedge clk_pci);
        stop_pin_n = p[0];
        wr({2'b00, b[0]});
        edges(3);
        chk(cfg_rdata[0] == (p[0] & b[0]), "R4 R2 readback combo", cfg_rdata[0], p & b);
        chk(pci_clk_out == {NS{p[0] & b[0]}}, "R2 outputs combo", pci_clk_out, (p & b) ? 15 : 0);
      end
    end
    stop_pin_n = 1'b1;
    wr(3'b001);
    edges(3);
  endtask

  task automatic t_free;
    wr(3'b011);            // free-run bit for pcif_clk_out[0]
    set_pin(1'b0);
    edges(3);
    chk(pcif_clk_out == 2'b01, "R5 free output ignores pin stop", pcif_clk_out, 1);
    chk(cfg_rdata == 3'b010, "R4 free bits and run state readback", cfg_rdata, 2);
    stop_pin_n = 1'b1;
    wr(3'b010);            // register stop, free bit kept
    edges(3);
    chk(pcif_clk_out == 2'b01, "R5 free output ignores register stop", pcif_clk_out, 1);
    chk(pci_clk_out == '0, "R2 register stop alone", pci_clk_out, 0);
    wr(3'b000);            // clear free bit while stopped
    chk(pcif_clk_out == 2'b01, "R9 free change not before k+1", pcif_clk_out, 1);
    edges(1);
    chk(pcif_clk_out == 2'b00, "R5 cleared bit parks low", pcif_clk_out, 0);
    wr(3'b001);
    edges(2);
    chk(pcif_clk_out == 2'b11, "R6 all back", pcif_clk_out, 3);
  endtask

  initial begin
    repeat (4) @(posedge clk_pci);
    @(negedge clk_pci);
    rst_n = 1'b1;
    t_reset();
    t_pin_stop();
    t_reg_stop();
    t_combos();
    t_free();
    edges(4);
    chk(runts == 0, "R7 no shortened pulse", runts, 0);
    chk(pulses > 0, "R7 pulses observed", pulses, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 8.0);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule